// File: doc/BRIEF.md
# Two-Phase Microsecond Pulse Timer

This block drives a single output pulse with two timed phases. The first phase holds the output high and the second holds it low. Each phase length is a 16-bit count of microsecond ticks. Both counts enter through one shared 16-bit word input. The first write strobe stores the high-phase count, and the next strobe stores the low-phase count.

A prescaler runs on the 8 MHz system clock and produces a one-cycle enable every eighth clock, so one tick lasts 1 µs. The whole design runs on that one clock, and no derived clock is created. A start request is honoured only when the block is idle and both counts have been written. Accepting a start resets the prescaler, so the first tick of a run is a full microsecond. A count of zero skips its phase.

`busy_o` covers the whole run. When the run ends, `done_o` pulses for one cycle and the output rests low.

Top module: `pulse_timer`

## Requirements
- R1: After a synchronous active-high reset, `pulse_o`, `busy_o` and `done_o` are 0, and no counts are held, so `go` has no effect until two words have been written.
- R2: While idle, the first `cfg_wr` strobe after reset or after an accepted start stores the high count. The next strobe stores the low count. Further strobes keep alternating between the two.
- R3: `go` is accepted only when the block is idle and both counts have been written at least once since reset. At any other time `go` has no visible effect.
- R4: When `go` is accepted at clock edge E0 with a nonzero high count H, `pulse_o` is 1 from E0 for exactly 8·H cycles. This holds however long the block sat idle before E0.
- R5: After the high phase, `pulse_o` is 0 and `busy_o` stays 1 for exactly 8·L more cycles, where L is the low count. `busy_o` is therefore 1 for exactly 8·(H+L) cycles from E0.
- R6: `done_o` is 1 for exactly one cycle, set at the same edge where `busy_o` falls. `pulse_o` is 0 from then on.
- R7: With H = 0, `pulse_o` never goes high during the run, and the run lasts 8·L cycles.
- R8: With L = 0, `done_o` is set at the edge that ends the high phase.
- R9: With H = L = 0, `done_o` is set at E0 itself and `busy_o` never rises.
- R10: `cfg_wr` strobes during a run change neither the running phase lengths nor the stored counts. A later run started without new writes repeats the old timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (8 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Phase count word, in microsecond ticks |
| cfg_wr | input | 1 | Write strobe for `cfg_word` |
| go | input | 1 | Start request |
| pulse_o | output | 1 | Timed pulse output |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle end-of-run flag |

## Verification
The tick divider, the remaining-tick counter and the phase state cannot be seen directly. Each of them still shows up in edge timing at the ports within one run. A prescaler that is not restarted, or that wraps at the wrong count, makes a phase up to seven cycles short or long. An off-by-one in the remaining-tick counter moves the pulse edge or the done flag by a whole tick of 8 cycles. A wrong load pointer or a write that slips through during a run swaps or replaces a phase length, and that shows on the next run. Sweeping every small pair of counts with different idle gaps exposes each of these faults as an exact cycle mismatch.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    parameter int CNT_W     = 16;
    parameter int DIV_RATIO = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t ph;
        logic   level;
        logic   run;
        logic   fin;
    } seq_t;

    // Which phase a run opens with, given which counts are zero.
    function automatic phase_t entry_phase(input logic hi_zero, input logic lo_zero);
        if (!hi_zero)      return PH_HIGH;
        else if (!lo_zero) return PH_LOW;
        else               return PH_IDLE;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = pgen_pkg::DIV_RATIO
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart)      phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/count_loader.sv
module count_loader #(
    parameter int CNT_W = pgen_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] word,
    input  logic             lock,
    input  logic             rearm,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] lo_cnt,
    output logic             ready
);
    logic sel_lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= '0;
            lo_cnt   <= '0;
            sel_lo_q <= 1'b0;
            ready    <= 1'b0;
        end else if (rearm) begin
            sel_lo_q <= 1'b0;
        end else if (wr && !lock) begin
            if (!sel_lo_q) begin
                hi_cnt   <= word;
                sel_lo_q <= 1'b1;
            end else begin
                lo_cnt   <= word;
                sel_lo_q <= 1'b0;
                ready    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
    import pgen_pkg::*;
#(
    parameter int CNT_W = pgen_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             ready,
    input  logic             tick,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    output logic             accept,
    output logic             level,
    output logic             run,
    output logic             fin
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_t             st_q;
    logic [CNT_W-1:0] left_q;
    logic             last_tick;
    logic             lo_zero;

    assign accept    = go && ready && (st_q.ph == PH_IDLE);
    assign last_tick = tick && (left_q == ONE);
    assign lo_zero   = (lo_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '{ph: PH_IDLE, level: 1'b0, run: 1'b0, fin: 1'b0};
            left_q <= '0;
        end else begin
            st_q.fin <= 1'b0;
            unique case (st_q.ph)
                PH_IDLE: begin
                    if (accept) begin
                        unique case (entry_phase(hi_cnt == '0, lo_zero))
                            PH_HIGH: begin
                                st_q.ph    <= PH_HIGH;
                                st_q.level <= 1'b1;
                                st_q.run   <= 1'b1;
                                left_q     <= hi_cnt;
                            end
                            PH_LOW: begin
                                st_q.ph  <= PH_LOW;
                                st_q.run <= 1'b1;
                                left_q   <= lo_cnt;
                            end
                            default: st_q.fin <= 1'b1;
                        endcase
                    end
                end
                PH_HIGH: begin
                    if (last_tick) begin
                        st_q.level <= 1'b0;
                        if (!lo_zero) begin
                            st_q.ph <= PH_LOW;
                            left_q  <= lo_cnt;
                        end else begin
                            st_q.ph  <= PH_IDLE;
                            st_q.run <= 1'b0;
                            st_q.fin <= 1'b1;
                        end
                    end else if (tick) begin
                        left_q <= left_q - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (last_tick) begin
                        st_q.ph  <= PH_IDLE;
                        st_q.run <= 1'b0;
                        st_q.fin <= 1'b1;
                    end else if (tick) begin
                        left_q <= left_q - 1'b1;
                    end
                end
                default: begin
                    st_q.ph    <= PH_IDLE;
                    st_q.level <= 1'b0;
                    st_q.run   <= 1'b0;
                end
            endcase
        end
    end

    assign level = st_q.level;
    assign run   = st_q.run;
    assign fin   = st_q.fin;
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int CNT_W = pgen_pkg::CNT_W,
    parameter int DIV   = pgen_pkg::DIV_RATIO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_word,
    input  logic             cfg_wr,
    input  logic             go,
    output logic             pulse_o,
    output logic             busy_o,
    output logic             done_o
);
    logic             tick;
    logic             accept;
    logic             ready;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;

    tick_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .tick    (tick)
    );

    count_loader #(.CNT_W(CNT_W)) u_load (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .word   (cfg_word),
        .lock   (busy_o || accept),
        .rearm  (accept),
        .hi_cnt (hi_cnt),
        .lo_cnt (lo_cnt),
        .ready  (ready)
    );

    phase_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .ready  (ready),
        .tick   (tick),
        .hi_cnt (hi_cnt),
        .lo_cnt (lo_cnt),
        .accept (accept),
        .level  (pulse_o),
        .run    (busy_o),
        .fin    (done_o)
    );
endmodule

// File: rtl/pulse_timer_chk.sv
module pulse_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic             go,
    input logic             pulse_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [CNT_W-1:0] hi_cnt,
    input logic [CNT_W-1:0] lo_cnt
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!pulse_o && !busy_o && !done_o));

    assert_start_needs_go_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(go));

    assert_pulse_inside_run_R4: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> busy_o);

    assert_no_rise_midrun_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(!busy_o));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_with_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (done_o && !pulse_o));

    assert_load_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cfg_wr) |=> ($stable(hi_cnt) && $stable(lo_cnt)));
endmodule

bind pulse_timer pulse_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_wr  (cfg_wr),
    .go      (go),
    .pulse_o (pulse_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_cnt  (hi_cnt),
    .lo_cnt  (lo_cnt)
);

// File: tb/sim_pulse_timer.sv
`timescale 1ns/1ps
module sim_pulse_timer;
    localparam int W  = 16;
    localparam int DV = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cfg_word = '0;
    logic         cfg_wr = 1'b0;
    logic         go = 1'b0;
    logic         pulse_o, busy_o, done_o;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    pulse_timer #(.CNT_W(W), .DIV(DV)) u0 (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .cfg_wr(cfg_wr), .go(go),
        .pulse_o(pulse_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errs++;
            checks++;
            $display("FAIL R4 watchdog actual=%0d cycles expected=completion", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_word(input int v);
        @(negedge clk);
        cfg_word = W'(v);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Accept go at the next edge E0 and compare every sample against the expected timing.
    task automatic run(input int h, input int l, input int gap, input bit inject, input string req);
        int t = DV * (h + l);
        int hi_seen = 0, busy_seen = 0, done_at = -1;
        int bad_p = 0, bad_b = 0, bad_d = 0;
        repeat (gap) @(negedge clk);
        go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
        for (int k = 0; k <= t + 1; k++) begin
            if (pulse_o) hi_seen++;
            if (busy_o) busy_seen++;
            if (done_o && done_at < 0) done_at = k;
            if (pulse_o !== (k < DV * h)) bad_p++;
            if (busy_o !== (k < t)) bad_b++;
            if (done_o !== (k == t)) bad_d++;
            if (inject) begin
                // R10: writes and a repeated go in the middle of a run
                cfg_wr = (k == 2 || k == 4);
                go = (k == 3);
                cfg_word = W'(9 + k);
            end
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        go = 1'b0;
        chk(bad_p == 0, {req, " pulse high cycles"}, hi_seen, DV * h);
        chk(bad_b == 0, {req, " busy cycles"}, busy_seen, t);
        chk(bad_d == 0, {req, " done index"}, done_at, t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        chk(pulse_o == 0 && busy_o == 0 && done_o == 0, "R1 reset outputs", {pulse_o, busy_o, done_o}, 0);
        // R1/R3: go before any count written is ignored
        go = 1'b1;
        repeat (4) @(negedge clk);
        go = 1'b0;
        begin
            int act = 0;
            for (int k = 0; k < 20; k++) begin
                act |= {pulse_o, busy_o, done_o};
                @(negedge clk);
            end
            chk(act == 0, "R3 go ignored when unloaded", act, 0);
        end
        // R3: high only written, still not ready
        wr_word(2);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && done_o == 0, "R3 go ignored with one count", busy_o, 0);
        wr_word(1);
        // R2: order high then low
        run(2, 1, 0, 1'b0, "R2 load order");

        // Sweep: R4 R5 R7 R8 R9 with varied idle gaps
        for (int h = 0; h <= 4; h++) begin
            for (int l = 0; l <= 4; l++) begin
                string tag;
                wr_word(h);
                wr_word(l);
                if (h == 0 && l == 0)  tag = "R9 both zero";
                else if (h == 0)       tag = "R7 zero high";
                else if (l == 0)       tag = "R8 zero low";
                else                   tag = "R4 R5 R6 timing";
                run(h, l, (h * 5 + l * 3) % 11, 1'b0, tag);
            end
        end

        // R10: writes during a run ignored, timing repeats afterwards
        wr_word(3);
        wr_word(2);
        run(3, 2, 1, 1'b1, "R10 run with writes");
        run(3, 2, 4, 1'b0, "R10 repeat old counts");
        // R2: pointer back at high after start; one write replaces high only
        wr_word(1);
        run(1, 2, 2, 1'b0, "R2 pointer rearmed");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule